// File: doc/BRIEF.md
# Burst Beat Address Generator

This block works out the byte address of every data beat in a memory-mapped burst. A requester presents a start address, a two-bit mode, a beat-count field and a beat-size field, and pulses the load strobe. From the next cycle the block drives the address of beat zero. Each pulse on the advance strobe steps it to the next beat. Only the start address is supplied from outside; every later address is generated inside the block.

Three sequencing modes are supported. In the fixed mode every beat repeats the start address, which suits a queue or a register port. In the incrementing mode each beat moves forward by the beat size. In the wrapping mode the address moves forward in the same way but folds back to the bottom of an aligned window, which suits cache-line fills that start at the critical word. The block raises a flag on the final beat and holds a busy flag from the load until that final beat has been advanced.

Top module: `burst_addr_gen`

## Requirements
- R1: A load strobe seen while not busy is accepted: in the next cycle busy_o is 1 and addr_o equals the start address presented with the strobe.
- R2: Mode 2'b00 (fixed) gives every beat the start address.
- R3: Mode 2'b01 (incrementing) gives beat 0 the start address as supplied and beat k (k >= 1) the address floor(start / B) * B + k * B, where B = 2^size bytes.
- R4: Mode 2'b10 (wrapping) with len in {1, 3, 7, 15} uses a window of W = (len+1) * B bytes whose base is the start address rounded down to a multiple of W; beat k (k >= 1) is base + ((floor(start / B) * B - base + k * B) mod W).
- R5: Mode 2'b11, and mode 2'b10 with len not in {1, 3, 7, 15}, sequence exactly like the incrementing mode.
- R6: A size field above log2 of the bus width in bytes is clamped to that value (8-byte bus by default, so sizes 4 to 7 act as size 3).
- R7: A burst has len+1 beats; last_o is 1 exactly while the current beat index equals len, and busy_o is 0 in the cycle after the advance of that last beat.
- R8: An advance strobe while not busy has no effect: busy_o stays 0 and addr_o keeps its value.
- R9: A load strobe while busy is ignored: the running burst keeps its address and beat position.
- R10: After reset busy_o and last_o are 0 and addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Burst request strobe |
| start_addr_i | input | ADDR_W | Address of the first beat |
| mode_i | input | 2 | Sequencing mode: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| len_i | input | 8 | Number of beats minus one |
| size_i | input | 3 | log2 of bytes per beat |
| advance_i | input | 1 | Data beat taken; step to the next beat |
| addr_o | output | ADDR_W | Address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress |

## Verification
The hardest case to reach is a wrapping burst that starts at an unaligned address in the middle of its window with a clamped size, because the alignment, the fold and the clamp then act on the same beat. The sweep covers every mode code, sizes 0 to 4, lengths 0, 1, 3, 5, 7 and 15, and starts that are aligned, unaligned and mid-window, so each combination occurs. Gaps are placed between advances, and a second load is offered in those gaps, so the ignore rules are exercised while a burst is in flight.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int LEN_W  = 8;
  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;

  function automatic logic wrap_len_ok(input logic [LEN_W-1:0] len);
    return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
  endfunction
endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        mode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  output burst_e            kind_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] mask_o
);
  localparam int MAX_SIZE = $clog2(BUS_BYTES);

  logic [SIZE_W-1:0] eff_size;
  burst_e            eff_kind;
  logic [ADDR_W-1:0] span, win_mask;

  generate
    if (MAX_SIZE >= (1 << SIZE_W) - 1) begin : g_no_clamp
      assign eff_size = size_i;
    end else begin : g_clamp
      assign eff_size = (size_i > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : size_i;
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      2'b00:   eff_kind = BURST_FIXED;
      2'b10:   eff_kind = wrap_len_ok(len_i) ? BURST_WRAP : BURST_INCR;
      default: eff_kind = BURST_INCR;
    endcase
  end

  assign span     = (ADDR_W'(len_i) + ADDR_W'(1)) << eff_size;
  assign win_mask = span - ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= BURST_FIXED;
      len_o  <= '0;
      size_o <= '0;
      base_o <= '0;
      mask_o <= '0;
    end else if (take_i) begin
      kind_o <= eff_kind;
      len_o  <= len_i;
      size_o <= eff_size;
      base_o <= start_addr_i & ~win_mask;
      mask_o <= win_mask;
    end
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter
  import burst_addr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             last_o
);
  logic [LEN_W-1:0] idx_q;

  assign last_o = busy_o && (idx_q == len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_q  <= '0;
    end else if (take_i) begin
      busy_o <= 1'b1;
      idx_q  <= '0;
    end else if (step_i) begin
      if (last_o) busy_o <= 1'b0;
      else        idx_q  <= idx_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/addr_step.sv
module addr_step
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  burst_e            kind_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic [ADDR_W-1:0] cur_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] stride, aligned, sum;

  assign stride  = ADDR_W'(1) << size_i;
  assign aligned = cur_i & ~(stride - ADDR_W'(1));
  assign sum     = aligned + stride;

  always_comb begin
    unique case (kind_i)
      BURST_FIXED: next_o = cur_i;
      BURST_WRAP:  next_o = base_i | (sum & mask_i);
      default:     next_o = sum;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        mode_i,
  input  logic [7:0]        len_i,
  input  logic [2:0]        size_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              busy_o
);
  logic              take, step;
  burst_e            kind_q;
  logic [LEN_W-1:0]  len_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] base_q, mask_q, next_addr, addr_q;

  assign take = load_i && !busy_o;
  assign step = advance_i && busy_o;

  burst_cfg_reg #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) i_cfg (
    .clk_i, .rst_ni, .take_i(take), .start_addr_i, .mode_i, .len_i, .size_i,
    .kind_o(kind_q), .len_o(len_q), .size_o(size_q), .base_o(base_q), .mask_o(mask_q)
  );

  beat_counter i_cnt (
    .clk_i, .rst_ni, .take_i(take), .step_i(step), .len_i(len_q),
    .busy_o, .last_o
  );

  addr_step #(.ADDR_W(ADDR_W)) i_step (
    .kind_i(kind_q), .size_i(size_q), .base_i(base_q), .mask_i(mask_q),
    .cur_i(addr_q), .next_o(next_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               addr_q <= '0;
    else if (take)             addr_q <= start_addr_i;
    else if (step && !last_o)  addr_q <= next_addr;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              advance_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_o,
  input logic              busy_o,
  input burst_e            kind_q,
  input logic [SIZE_W-1:0] size_q
);
  a_r1_load_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !busy_o |=> busy_o && addr_o == $past(start_addr_i));

  a_r2_fixed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && advance_i && !last_o && kind_q == BURST_FIXED |=> $stable(addr_o));

  a_r3_incr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && advance_i && !last_o && kind_q == BURST_INCR
    |=> (addr_o & ((ADDR_W'(1) << $past(size_q)) - ADDR_W'(1))) == '0);

  a_r7_last_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> busy_o);

  a_r7_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && advance_i |=> !busy_o);

  a_r8_idle_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && advance_i && !load_i |=> !busy_o && $stable(addr_o));

  a_r9_load_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && load_i && !advance_i |=> busy_o && $stable(addr_o));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .advance_i(advance_i),
  .start_addr_i(start_addr_i), .addr_o(addr_o), .last_o(last_o), .busy_o(busy_o),
  .kind_q(kind_q), .size_q(size_q)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic              load_i = 1'b0, advance_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [1:0]        mode_i = '0;
  logic [7:0]        len_i = '0;
  logic [2:0]        size_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic              last_o, busy_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BUS_BYTES(8)) i_burst_addr_gen (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint exp_addr(longint start, int mode, int len, int size, int k);
    int es = (size > 3) ? 3 : size;
    longint b = longint'(1) << es;
    bit wrap = (mode == 2) && (len == 1 || len == 3 || len == 7 || len == 15);
    longint al, span, base;
    if (k == 0 || mode == 0) return start;
    al = (start / b) * b;
    if (wrap) begin
      span = longint'(len + 1) * b;
      base = (start / span) * span;
      return base + ((al - base + longint'(k) * b) % span);
    end
    return al + longint'(k) * b;
  endfunction

  function automatic string mode_tag(int mode, int len, int size);
    if (size > 3) return "R6";
    if (mode == 0) return "R2";
    if (mode == 1) return "R3";
    if (mode == 2 && (len == 1 || len == 3 || len == 7 || len == 15)) return "R4";
    return "R5";
  endfunction

  task automatic run_burst(input longint start, input int mode, input int len, input int size);
    string tag = mode_tag(mode, len, size);
    longint held;
    @(negedge clk_i);
    load_i = 1'b1; start_addr_i = ADDR_W'(start);
    mode_i = 2'(mode); len_i = 8'(len); size_i = 3'(size);
    @(negedge clk_i);
    load_i = 1'b0;
    check(busy_o == 1'b1, "R1", busy_o, 1);
    check(addr_o == ADDR_W'(start), "R1", addr_o, start);
    for (int k = 0; k <= len; k++) begin
      longint e = exp_addr(start, mode, len, size, k);
      check(addr_o == ADDR_W'(e), tag, addr_o, e);
      check(last_o == (k == len), "R7", last_o, (k == len));
      if (k % 3 == 1) begin
        held = addr_o;
        load_i = 1'b1; start_addr_i = ADDR_W'(start + 'h400); mode_i = 2'b01;
        @(negedge clk_i);
        load_i = 1'b0;
        check(busy_o && addr_o == ADDR_W'(held) && last_o == (k == len), "R9", addr_o, held);
      end
      advance_i = 1'b1;
      @(negedge clk_i);
      advance_i = 1'b0;
    end
    check(busy_o == 1'b0 && last_o == 1'b0, "R7", busy_o, 0);
    held = addr_o;
    advance_i = 1'b1;
    @(negedge clk_i);
    advance_i = 1'b0;
    check(busy_o == 1'b0 && addr_o == ADDR_W'(held), "R8", addr_o, held);
  endtask

  initial begin
    longint starts[3] = '{'h1000, 'h2037, 'h30a8};
    int lens[6] = '{0, 1, 3, 5, 7, 15};
    repeat (3) @(negedge clk_i);
    check(busy_o == 0 && last_o == 0 && addr_o == 0, "R10", addr_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    advance_i = 1'b1;
    @(negedge clk_i);
    advance_i = 1'b0;
    check(busy_o == 0 && addr_o == 0, "R8", addr_o, 0);
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 5; s++)
        for (int l = 0; l < 6; l++)
          for (int a = 0; a < 3; a++)
            run_burst(starts[a], m, lens[l], s);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule